// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block steps through a block transfer between a bank of eight low general registers and memory. It supports four kinds of transfer: a stack push, a stack pop, an ascending store of a register list at a base address, and an ascending load of a register list from a base address. The caller pulses `start` together with a register list, an extra-word flag (the link word on a push, the program-counter word on a pop), the index of the base register and the base value. The block then makes one word access per element through a request/ready memory port. It reads store data from, and writes load data into, an external register file through separate read and write ports.

When the last element is done, the block gives a one-cycle `done` pulse. Along with it come the final base value and a base write enable. For a pop that also took the program-counter word, it also raises a branch request that carries that word with its lowest bit cleared, so the surrounding core can redirect and refill its fetch pipeline.

Top module: `lsm_seq_top`

## Requirements
- R1: With `opSel`=0 (push), the link word `linkVal` (when `withLinkPc`=1) is stored first at `baseVal`-4. The listed registers follow from the highest index down to the lowest, each at the next lower word. The final base is `baseVal`-4·n, where n is the number of words moved.
- R2: With `opSel`=1 (pop), the listed registers are loaded from the lowest index up to the highest, starting at `baseVal` and going up one word at a time. The final base is `baseVal`+4·n.
- R3: A pop with `withLinkPc`=1 loads one more word after the listed registers. That word does not go to the register file. Alongside `done`, `branchReq` is 1 and `branchPc` carries that word with bit 0 cleared.
- R4: With `opSel`=2 (store-multiple), the listed registers are stored in ascending index order starting at `baseVal` with its two low bits cleared. The final base `baseVal`+4·n is always written back.
- R5: With `opSel`=3 (load-multiple), the listed registers are loaded in ascending index order from word-aligned addresses. The final base `baseVal`+4·n is written back (`baseWe`=1) only when bit `baseIdx` of the list is 0. `withLinkPc` has no effect on store-multiple or load-multiple.
- R6: After the last accepted access of a pop or load-multiple, there is one idle cycle before `done`. A push or store-multiple raises `done` in the cycle right after its last accepted access.
- R7: If no word is to be moved, `done` rises in the cycle after `start` and no memory access is made. `baseWe` and `branchReq` stay 0.
- R8: `memAddr` always has its two low bits at 0. While `memReq`=1 and `memReady`=0, the request, address, direction and store data hold. Each element is accepted exactly once.
- R9: `done` lasts one cycle. `baseWe` and `branchReq` are only ever 1 together with `done`. `busy` is 1 from the cycle after an accepted `start` through `done`. A `start` while busy is ignored. The operands are captured when `start` is accepted, and later changes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| opSel | input | 2 | 0 push, 1 pop, 2 store-multiple, 3 load-multiple |
| regList | input | NUM_REGS | One bit per low register to transfer |
| withLinkPc | input | 1 | Push: also store the link word; pop: also load the program counter |
| baseIdx | input | IDX_W | Index of the base register (store/load-multiple) |
| baseVal | input | DATA_W | Start value of the base (stack pointer or base register) |
| linkVal | input | DATA_W | Link word stored by a push |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for a store, 0 for a load |
| memAddr | output | DATA_W | Word-aligned access address |
| memWdata | output | DATA_W | Store data |
| memRdata | input | DATA_W | Load data, valid with `memReady` |
| memReady | input | 1 | Access accepted this cycle |
| regRdIdx | output | IDX_W | Register file read index |
| regRdData | input | DATA_W | Register file read data (same cycle) |
| regWe | output | 1 | Register file write enable |
| regWrIdx | output | IDX_W | Register file write index |
| regWrData | output | DATA_W | Register file write data |
| baseOut | output | DATA_W | Final base value, valid with `done` |
| baseWe | output | 1 | Base writeback enable, with `done` |
| branchReq | output | 1 | Popped program counter must be taken |
| branchPc | output | DATA_W | Popped program counter, bit 0 cleared |

## Verification
The bench builds the block with its default parameters: eight low registers and 32-bit words, so a single transfer moves at most nine words. Base values are placed inside a 64-word memory model, so every push, pop and list access lands in the modelled window, and the unaligned base values used for store-multiple and load-multiple exercise the address alignment. Random `memReady` stalls, operands scrambled after `start`, and a second `start` during a long transfer reach the holding, capture and busy-ignore behaviour. Directed cases cover the empty lists, the lone link or program-counter word, and a load-multiple base both inside and outside the list.

// File: rtl/lsm_seq_pkg.sv
package lsm_seq_pkg;

  typedef enum logic [1:0] {
    XOP_PUSH = 2'd0,
    XOP_POP  = 2'd1,
    XOP_STM  = 2'd2,
    XOP_LDM  = 2'd3
  } xferOp_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_XFER,
    SQ_TAIL,
    SQ_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch operands of a new transfer
    logic advance;   // current element accepted by memory
  } seqStrobe_t;

endpackage

// File: rtl/lsm_seq_ctrl.sv
module lsm_seq_ctrl
  import lsm_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       reqEmpty,
  input  logic       lastElem,
  input  logic       isLoadOp,
  input  logic       memReady,
  output seqStrobe_t strobe,
  output logic       memReq,
  output logic       busy,
  output logic       done
);

  seqState_e st, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= SQ_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    strobe = '0;
    unique case (st)
      SQ_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          stNext = reqEmpty ? SQ_DONE : SQ_XFER;
        end
      end
      SQ_XFER: begin
        if (memReady) begin
          strobe.advance = 1'b1;
          if (lastElem) stNext = isLoadOp ? SQ_TAIL : SQ_DONE;
        end
      end
      SQ_TAIL: stNext = SQ_DONE;
      SQ_DONE: stNext = SQ_IDLE;
      default: stNext = SQ_IDLE;
    endcase
  end

  assign memReq = (st == SQ_XFER);
  assign busy   = (st != SQ_IDLE);
  assign done   = (st == SQ_DONE);

  // R7: nothing to move finishes in the next cycle without an access
  a_r7_empty_done: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && reqEmpty) |=> (done && !memReq));

  // R6: loads pause one cycle before done, stores finish at once
  a_r6_load_tail: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && lastElem && isLoadOp) |=> (!done && !memReq) ##1 done);

  a_r6_store_finish: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && lastElem && !isLoadOp) |=> done);

  // R9: done is a single-cycle pulse, busy holds until done
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: rtl/lsm_seq_dp.sv
module lsm_seq_dp
  import lsm_seq_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  xferOp_e             startOp,
  input  logic [NUM_REGS-1:0] startList,
  input  logic                startExtra,
  input  logic [IDX_W-1:0]    startBaseIdx,
  input  logic [DATA_W-1:0]   startBase,
  input  logic [DATA_W-1:0]   linkVal,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic [DATA_W-1:0]   regRdData,
  output logic                reqEmpty,
  output logic                lastElem,
  output logic                isLoadOp,
  output logic                memWe,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [IDX_W-1:0]    regRdIdx,
  output logic [IDX_W-1:0]    regWrIdx,
  output logic [DATA_W-1:0]   regWrData,
  output logic                regWeQual,
  output logic [DATA_W-1:0]   baseOut,
  output logic                baseWeQual,
  output logic                branchFlag,
  output logic [DATA_W-1:0]   branchPc
);

  localparam int WORD_BYTES              = DATA_W / 8;
  localparam logic [DATA_W-1:0] STEP      = DATA_W'(WORD_BYTES);
  localparam logic [DATA_W-1:0] ALIGN_MSK = ~DATA_W'(WORD_BYTES - 1);
  localparam int CNT_W                   = $clog2(NUM_REGS + 2);

  xferOp_e             opQ;
  logic [NUM_REGS-1:0] pendMask;
  logic                pendExtra;
  logic                extraQ;
  logic                baseInList;
  logic                anyXfer;
  logic [DATA_W-1:0]   ptr;
  logic [DATA_W-1:0]   pcQ;

  logic                isPush;
  logic                extraAllowed;
  logic [IDX_W-1:0]    lowIdx, highIdx, curIdx;
  logic                lowHit;
  logic                curIsExtra;
  logic [CNT_W-1:0]    pendCount;

  assign isPush       = (opQ == XOP_PUSH);
  assign extraAllowed = (startOp == XOP_PUSH) || (startOp == XOP_POP);
  assign reqEmpty     = (startList == '0) && !(startExtra && extraAllowed);

  // lowest and highest pending register
  always_comb begin
    lowIdx = '0;
    lowHit = 1'b0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (pendMask[i]) begin
        lowIdx = IDX_W'(i);
        lowHit = 1'b1;
      end
    end
  end

  always_comb begin
    highIdx = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (pendMask[i]) highIdx = IDX_W'(i);
    end
  end

  // push takes the extra word first and walks down, the rest walk up
  always_comb begin
    if (isPush) begin
      curIsExtra = pendExtra;
      curIdx     = highIdx;
    end else begin
      curIsExtra = pendExtra && !lowHit;
      curIdx     = lowIdx;
    end
  end

  always_comb begin
    pendCount = CNT_W'(pendExtra);
    for (int i = 0; i < NUM_REGS; i++) pendCount = pendCount + CNT_W'(pendMask[i]);
  end
  assign lastElem = (pendCount == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ        <= XOP_PUSH;
      pendMask   <= '0;
      pendExtra  <= 1'b0;
      extraQ     <= 1'b0;
      baseInList <= 1'b0;
      anyXfer    <= 1'b0;
      ptr        <= '0;
      pcQ        <= '0;
    end else if (strobe.capture) begin
      opQ        <= startOp;
      pendMask   <= startList;
      pendExtra  <= startExtra && extraAllowed;
      extraQ     <= startExtra && extraAllowed;
      baseInList <= startList[startBaseIdx];
      anyXfer    <= !reqEmpty;
      ptr        <= startBase;
      pcQ        <= '0;
    end else if (strobe.advance) begin
      if (curIsExtra) pendExtra <= 1'b0;
      else            pendMask[curIdx] <= 1'b0;
      ptr <= isPush ? (ptr - STEP) : (ptr + STEP);
      if (curIsExtra && (opQ == XOP_POP)) pcQ <= memRdata & ~DATA_W'(1);
    end
  end

  assign memWe      = (opQ == XOP_PUSH) || (opQ == XOP_STM);
  assign isLoadOp   = !memWe;
  assign memAddr    = (isPush ? (ptr - STEP) : ptr) & ALIGN_MSK;
  assign memWdata   = curIsExtra ? linkVal : regRdData;
  assign regRdIdx   = curIdx;
  assign regWrIdx   = curIdx;
  assign regWrData  = memRdata;
  assign regWeQual  = isLoadOp && !curIsExtra;
  assign baseOut    = ptr;
  assign baseWeQual = anyXfer && !((opQ == XOP_LDM) && baseInList);
  assign branchFlag = extraQ && (opQ == XOP_POP);
  assign branchPc   = pcQ;

  // R1: successive push accesses step one word down
  a_r1_push_descends: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && isPush && !lastElem) |=> (memAddr == $past(memAddr) - STEP));

  // R2, R4, R5: other transfers step one word up
  a_r4_list_ascends: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !isPush && !lastElem) |=> (memAddr == $past(memAddr) + STEP));

  // R5: base in the load list blocks writeback
  a_r5_ldm_base_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && (startOp == XOP_LDM) && startList[startBaseIdx]) |=> !baseWeQual);

endmodule

// File: rtl/lsm_seq_top.sv
module lsm_seq_top
  import lsm_seq_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [1:0]          opSel,
  input  logic [NUM_REGS-1:0] regList,
  input  logic                withLinkPc,
  input  logic [IDX_W-1:0]    baseIdx,
  input  logic [DATA_W-1:0]   baseVal,
  input  logic [DATA_W-1:0]   linkVal,
  output logic                busy,
  output logic                done,
  output logic                memReq,
  output logic                memWe,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic                memReady,
  output logic [IDX_W-1:0]    regRdIdx,
  input  logic [DATA_W-1:0]   regRdData,
  output logic                regWe,
  output logic [IDX_W-1:0]    regWrIdx,
  output logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   baseOut,
  output logic                baseWe,
  output logic                branchReq,
  output logic [DATA_W-1:0]   branchPc
);

  seqStrobe_t strobe;
  logic       reqEmpty, lastElem, isLoadOp;
  logic       regWeQual, baseWeQual, branchFlag;

  lsm_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .reqEmpty (reqEmpty),
    .lastElem (lastElem),
    .isLoadOp (isLoadOp),
    .memReady (memReady),
    .strobe   (strobe),
    .memReq   (memReq),
    .busy     (busy),
    .done     (done)
  );

  lsm_seq_dp #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .startOp      (xferOp_e'(opSel)),
    .startList    (regList),
    .startExtra   (withLinkPc),
    .startBaseIdx (baseIdx),
    .startBase    (baseVal),
    .linkVal      (linkVal),
    .memRdata     (memRdata),
    .regRdData    (regRdData),
    .reqEmpty     (reqEmpty),
    .lastElem     (lastElem),
    .isLoadOp     (isLoadOp),
    .memWe        (memWe),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .regRdIdx     (regRdIdx),
    .regWrIdx     (regWrIdx),
    .regWrData    (regWrData),
    .regWeQual    (regWeQual),
    .baseOut      (baseOut),
    .baseWeQual   (baseWeQual),
    .branchFlag   (branchFlag),
    .branchPc     (branchPc)
  );

  assign regWe     = memReq && memReady && regWeQual;
  assign baseWe    = done && baseWeQual;
  assign branchReq = done && branchFlag;

  // R8: a stalled request holds its address, direction and data
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R9: side results only with done
  a_r9_basewe_with_done: assert property (@(posedge clk) disable iff (!rstN)
    baseWe |-> done);

  // R3: branch request carries an even address and comes with done
  a_r3_branch_even: assert property (@(posedge clk) disable iff (!rstN)
    branchReq |-> (done && !branchPc[0]));

  // R2, R5: register writes only from accepted loads
  a_r5_regwe_on_load: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (memReq && memReady && !memWe));

endmodule

// File: tb/test_lsm_seq_top.sv
module test_lsm_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int DW   = 32;
  localparam int MEMW = 64;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rstN;
  logic          start;
  logic [1:0]    opSel;
  logic [NREG-1:0] regList;
  logic          withLinkPc;
  logic [2:0]    baseIdx;
  logic [DW-1:0] baseVal, linkVal;
  logic          busy, done, memReq, memWe, memReady;
  logic [DW-1:0] memAddr, memWdata, memRdata;
  logic [2:0]    regRdIdx, regWrIdx;
  logic [DW-1:0] regRdData, regWrData, baseOut, branchPc;
  logic          regWe, baseWe, branchReq;

  lsm_seq_top i_lsm_seq_top (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .regList(regList),
    .withLinkPc(withLinkPc), .baseIdx(baseIdx), .baseVal(baseVal), .linkVal(linkVal),
    .busy(busy), .done(done), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .regRdIdx(regRdIdx), .regRdData(regRdData), .regWe(regWe), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .baseOut(baseOut), .baseWe(baseWe),
    .branchReq(branchReq), .branchPc(branchPc)
  );

  // environment: register file and word memory
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] mem  [MEMW];
  logic [DW-1:0] refRegs [NREG];
  logic [DW-1:0] refMem  [MEMW];

  assign regRdData = regs[regRdIdx];
  assign memRdata  = mem[memAddr[7:2]];

  always @(posedge clk) begin
    if (memReq && memReady && memWe) mem[memAddr[7:2]] <= memWdata;
    if (regWe) regs[regWrIdx] <= regWrData;
  end

  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [1:0] op);
    case (op)
      2'd0:    return "R1";
      2'd1:    return "R2";
      2'd2:    return "R4";
      default: return "R5";
    endcase
  endfunction

  // expected access list
  logic [DW-1:0] expAddr [10];
  logic          expWe   [10];
  logic [DW-1:0] expData [10];
  int            nExp;
  int            accIdx;
  logic [DW-1:0] expBase, expPc;
  logic          expBaseWe, expBranch;
  string         curReq;
  logic          stallOn = 1'b0;

  task automatic addAcc(input logic [DW-1:0] a, input logic we, input logic [DW-1:0] d);
    expAddr[nExp] = a & ~32'h3;
    expWe[nExp]   = we;
    expData[nExp] = d;
    nExp++;
  endtask

  // reference behaviour from the requirements
  task automatic model(input logic [1:0] op, input logic [7:0] lst, input logic fl,
                       input logic [2:0] bidx, input logic [DW-1:0] base, input logic [DW-1:0] lnk);
    logic [DW-1:0] p;
    p = base;
    nExp = 0;
    expBranch = 1'b0;
    expPc = '0;
    case (op)
      2'd0: begin
        if (fl) begin
          p = p - 4; addAcc(p, 1'b1, lnk); refMem[p[7:2]] = lnk;
        end
        for (int i = 7; i >= 0; i--) if (lst[i]) begin
          p = p - 4; addAcc(p, 1'b1, refRegs[i]); refMem[p[7:2]] = refRegs[i];
        end
      end
      2'd1: begin
        for (int i = 0; i < 8; i++) if (lst[i]) begin
          addAcc(p, 1'b0, '0); refRegs[i] = refMem[p[7:2]]; p = p + 4;
        end
        if (fl) begin
          addAcc(p, 1'b0, '0); expPc = refMem[p[7:2]] & ~32'h1; expBranch = 1'b1; p = p + 4;
        end
      end
      2'd2: begin
        for (int i = 0; i < 8; i++) if (lst[i]) begin
          addAcc(p, 1'b1, refRegs[i]); refMem[p[7:2]] = refRegs[i]; p = p + 4;
        end
      end
      default: begin
        for (int i = 0; i < 8; i++) if (lst[i]) begin
          addAcc(p, 1'b0, '0); refRegs[i] = refMem[p[7:2]]; p = p + 4;
        end
      end
    endcase
    expBase   = p;
    expBaseWe = (nExp > 0) && !((op == 2'd3) && lst[bidx]);
  endtask

  // memory side: ready pattern and access order check
  always @(negedge clk) begin
    memReady = stallOn ? ($urandom_range(0, 3) != 0) : 1'b1;
    if (rstN && memReq && memReady) begin
      if (accIdx >= nExp) begin
        chk("R8", "unexpected extra access", memAddr, '1);
      end else begin
        chk(curReq, "access address", memAddr, expAddr[accIdx]);
        chk(curReq, "access direction", {31'd0, memWe}, {31'd0, expWe[accIdx]});
        if (expWe[accIdx]) chk(curReq, "store data", memWdata, expData[accIdx]);
      end
      accIdx++;
    end
  end

  task automatic runOp(input logic [1:0] op, input logic [7:0] lst, input logic fl,
                       input logic [2:0] bidx, input logic [DW-1:0] base, input logic pulse);
    int cyc;
    int reqCyc;
    logic isLd;
    for (int i = 0; i < NREG; i++) refRegs[i] = regs[i];
    for (int i = 0; i < MEMW; i++) refMem[i] = mem[i];
    model(op, lst, fl, bidx, base, linkVal);
    curReq = reqOf(op);
    if (nExp == 0) curReq = "R7";
    isLd = (op == 2'd1) || (op == 2'd3);
    @(negedge clk);
    accIdx = 0;
    start = 1'b1; opSel = op; regList = lst; withLinkPc = fl; baseIdx = bidx; baseVal = base;
    @(negedge clk);
    // operands scrambled after capture (R9)
    start = 1'b0;
    opSel = 2'($urandom); regList = 8'($urandom); withLinkPc = 1'($urandom);
    baseIdx = 3'($urandom); baseVal = $urandom;
    cyc = 1; reqCyc = 0;
    while (!done && cyc < 500) begin
      if (memReq) reqCyc++;
      start = (pulse && cyc == 2);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk("R9", "done reached", {31'd0, done}, 32'd1);
    chk("R6", "cycles to done", cyc, reqCyc + ((isLd && nExp > 0) ? 1 : 0) + 1);
    chk(curReq, "accesses made", accIdx, nExp);
    chk(curReq, "base write enable", {31'd0, baseWe}, {31'd0, expBaseWe});
    if (nExp > 0) chk(curReq, "final base", baseOut, expBase);
    chk("R3", "branch request", {31'd0, branchReq}, {31'd0, expBranch});
    if (expBranch) chk("R3", "branch target", branchPc, expPc);
    @(negedge clk);
    chk("R9", "done one cycle", {30'd0, done, busy}, 32'd0);
    for (int i = 0; i < NREG; i++) chk(curReq, "register file", regs[i], refRegs[i]);
    for (int i = 0; i < MEMW; i++) if (mem[i] !== refMem[i]) chk(curReq, "memory word", mem[i], refMem[i]);
    nChecks++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rstN = 1'b0; start = 1'b0; opSel = '0; regList = '0; withLinkPc = 1'b0;
    baseIdx = '0; baseVal = '0; linkVal = 32'h1234_5679; memReady = 1'b1;
    accIdx = 0; nExp = 0; curReq = "R9";
    for (int i = 0; i < NREG; i++) regs[i] = $urandom;
    for (int i = 0; i < MEMW; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    chk("R9", "reset outputs", {26'd0, busy, done, memReq, regWe, baseWe, branchReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    runOp(2'd0, 8'h00, 1'b0, 3'd0, 32'h80, 1'b0);   // R7 empty push
    runOp(2'd2, 8'h00, 1'b1, 3'd0, 32'h80, 1'b0);   // R7 flag ignored on store-multiple
    runOp(2'd3, 8'h00, 1'b1, 3'd2, 32'h80, 1'b0);   // R5 flag ignored, empty
    runOp(2'd0, 8'h00, 1'b1, 3'd0, 32'h80, 1'b0);   // R1 link word only
    mem[32'h80 >> 2] = 32'hCAFE_0003;
    runOp(2'd1, 8'h00, 1'b1, 3'd0, 32'h80, 1'b0);   // R3 pc only, odd word
    runOp(2'd3, 8'h2C, 1'b0, 3'd3, 32'h71, 1'b0);   // R5 base in list
    runOp(2'd3, 8'h2C, 1'b0, 3'd4, 32'h72, 1'b0);   // R5 base not in list
    runOp(2'd2, 8'h91, 1'b0, 3'd1, 32'h63, 1'b0);   // R4 unaligned base
    stallOn = 1'b1;
    runOp(2'd0, 8'hFF, 1'b1, 3'd0, 32'h9C, 1'b1);   // R1 full push, start while busy
    runOp(2'd1, 8'hFF, 1'b1, 3'd0, 32'h78, 1'b1);   // R2 full pop with pc

    // constrained random mix
    for (int k = 0; k < 80; k++) begin
      linkVal = $urandom;
      runOp(2'($urandom), 8'($urandom), 1'($urandom), 3'($urandom),
            32'h60 + 32'($urandom_range(0, 63)), 1'($urandom_range(0, 3) == 0));
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule